// File: doc/BRIEF.md
# Two-wire slave port for a 7-bit wiper register

This block connects a 7-bit volatile wiper setting to a two-wire serial bus and acts only as a slave on that bus. A fast system clock oversamples the serial clock and data lines. Each line passes through a two-flop synchronizer and then an edge detector. A falling data edge while the clock is high opens a transaction, and a rising data edge while the clock is high closes it. The first byte of a transaction selects the device and gives the transfer direction. The fixed pattern `01010` fills bits 7..3, bits 2..1 must equal the two address strap inputs (strap_a[1] then strap_a[0]), and bit 0 is 1 for read and 0 for write.

A write carries an address byte and one data byte. Only address 0x00 exists, and the low seven bits of the data byte become the wiper setting. A read returns a single byte straight after the selection byte. That byte is a 0 followed by the seven register bits, most significant bit first. The block never drives the data line high. `sda_oe` = 1 pulls the line low, and 0 releases it.

The block is built around one state machine with these states:
- ST_IDLE waits for a START.
- ST_ID shifts in the selection byte. After eight bits it moves to ST_ID_ACK on a match, or back to ST_IDLE on a mismatch.
- ST_ID_ACK drives the acknowledge. It then moves to ST_TX for a read or to ST_ADDR for a write.
- ST_ADDR shifts in the address byte. It moves to ST_ADDR_ACK for 0x00, or to ST_IDLE for any other value.
- ST_ADDR_ACK moves to ST_DATA.
- ST_DATA moves to ST_DATA_ACK and commits the write at that point.
- ST_DATA_ACK moves to ST_WAIT_STOP.
- ST_TX sends eight bits and then moves to ST_WAIT_STOP.

A START in any state leads to ST_ID. A STOP in any state leads to ST_IDLE.

Top module: `wiper_i2c_port`

## Requirements
- R1: After reset the wiper register holds 64 (0x40), `sda_oe` is 0 and `wr_strobe` is 0.
- R2: Clock pulses and data bytes with no START before them get no acknowledge and do not change the register.
- R3: A selection byte with bits 7..3 = 01010 and bits 2..1 = strap_a[1:0] is acknowledged. The acknowledge is `sda_oe` = 1 during the ninth clock-high period.
- R4: A selection byte that does not match gets no acknowledge. The block then ignores all later bytes until the next START.
- R5: A write (selection byte with bit 0 = 0, address 0x00, data byte) is acknowledged after each of its three bytes. The register takes bits 6..0 of the data byte, and bit 7 is ignored. `wr_strobe` pulses for exactly one cycle per write.
- R6: An address byte other than 0x00 gets no acknowledge, and the data byte that follows is neither acknowledged nor written.
- R7: A read (selection byte with bit 0 = 1) is followed by one byte from the slave, MSB first. Bit 7 is 0 and bits 6..0 are the register. A 0 bit is sent as `sda_oe` = 1.
- R8: The data line is released during the master's acknowledge clock after the read byte. After a STOP the block is idle again.
- R9: A repeated START in the middle of a transaction aborts it without writing and begins a new selection byte.
- R10: A STOP in the middle of a write aborts it without writing, and later bytes are ignored until a START.
- R11: `sda_oe` changes only while the synchronized serial clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| strap_a | input | 2 | Address straps; bit 1 is compared with byte bit 2, bit 0 with byte bit 1 |
| sda_oe | output | 1 | 1 pulls the data line low |
| wr_strobe | output | 1 | One-cycle pulse when a write commits |
| wr_data | output | 7 | Value committed with `wr_strobe` |
| wiper_q | output | 7 | Current wiper register value |

## Verification
Every reaction is counted from a serial-clock edge. That edge reaches the detectors two system clocks later, and the state register responds on the third. As a result, `sda_oe` and `wr_strobe` change three clocks after the clock edge that causes them, and `wiper_q` changes one clock after that. The bench holds each serial clock phase for eight system clocks and samples the acknowledge and read bits in the middle of the clock-high phase, well clear of that latency. It reads the register and the strobe count only after the bus has gone quiet. A monitor records any change of `sda_oe` while the serial clock is high.

// File: rtl/wiper_i2c_pkg.sv
package wiper_i2c_pkg;

    localparam int BYTE_W = 8;

    localparam logic [4:0] ID_PREFIX = 5'b01010;

    localparam logic [BYTE_W-1:0] REG_ADDR = '0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID,
        ST_ID_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_WAIT_STOP
    } bus_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    localparam int NLINES = 2;

    logic [NLINES-1:0] line_raw;
    logic [NLINES-1:0] line_now;
    logic [NLINES-1:0] line_old;

    assign line_raw = {scl_in, sda_in};

    genvar g;
    generate
        for (g = 0; g < NLINES; g++) begin : g_line
            logic [STAGES:0] chain;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '1;
                end else begin
                    chain <= {chain[STAGES-1:0], line_raw[g]};
                end
            end

            assign line_now[g] = chain[STAGES-1];
            assign line_old[g] = chain[STAGES];
        end
    endgenerate

    assign scl_s     = line_now[1];
    assign sda_s     = line_now[0];
    assign scl_rise  = line_now[1] & ~line_old[1];
    assign scl_fall  = ~line_now[1] & line_old[1];
    assign start_evt = line_now[1] & line_old[1] & line_old[0] & ~line_now[0];
    assign stop_evt  = line_now[1] & line_old[1] & ~line_old[0] & line_now[0];

endmodule

// File: rtl/wiper_i2c_fsm.sv
module wiper_i2c_fsm
    import wiper_i2c_pkg::*;
#(
    parameter int DATA_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [1:0]        strap,
    input  logic [DATA_W-1:0] rd_value,
    output logic              sda_oe,
    output logic              wr_pulse,
    output logic [DATA_W-1:0] wr_byte
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam int PAD_W = BYTE_W - DATA_W;

    bus_state_e        state;
    bus_state_e        nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw_q;
    logic              byte_done;
    logic              id_ok;
    logic              addr_ok;
    logic              rx_state;

    assign byte_done = (bit_cnt == CNT_W'(BYTE_W));
    assign id_ok     = (shreg[BYTE_W-1:BYTE_W-5] == ID_PREFIX) && (shreg[2:1] == strap);
    assign addr_ok   = (shreg == REG_ADDR);
    assign rx_state  = (state == ST_ID) || (state == ST_ADDR) || (state == ST_DATA);

    always_comb begin
        nxt = state;
        if (start_evt) begin
            nxt = ST_ID;
        end else if (stop_evt) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_ID:        if (scl_fall && byte_done) nxt = id_ok ? ST_ID_ACK : ST_IDLE;
                ST_ID_ACK:    if (scl_fall) nxt = rw_q ? ST_TX : ST_ADDR;
                ST_ADDR:      if (scl_fall && byte_done) nxt = addr_ok ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (scl_fall) nxt = ST_DATA;
                ST_DATA:      if (scl_fall && byte_done) nxt = ST_DATA_ACK;
                ST_DATA_ACK:  if (scl_fall) nxt = ST_WAIT_STOP;
                ST_TX:        if (scl_fall && byte_done) nxt = ST_WAIT_STOP;
                ST_WAIT_STOP: nxt = ST_WAIT_STOP;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            rw_q     <= 1'b0;
            wr_pulse <= 1'b0;
            wr_byte  <= '0;
        end else begin
            state    <= nxt;
            wr_pulse <= (state == ST_DATA) && (nxt == ST_DATA_ACK);
            if ((state == ST_DATA) && (nxt == ST_DATA_ACK)) begin
                wr_byte <= shreg[DATA_W-1:0];
            end
            if ((state == ST_ID) && (nxt == ST_ID_ACK)) begin
                rw_q <= shreg[0];
            end
            if (start_evt || (nxt != state)) begin
                bit_cnt <= '0;
            end else if ((rx_state || state == ST_TX) && scl_rise) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
            if ((nxt == ST_TX) && (state != ST_TX)) begin
                shreg <= {{PAD_W{1'b0}}, rd_value};
            end else if (rx_state && scl_rise) begin
                shreg <= {shreg[BYTE_W-2:0], sda_s};
            end else if ((state == ST_TX) && scl_fall) begin
                shreg <= {shreg[BYTE_W-2:0], 1'b0};
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_ID_ACK, ST_ADDR_ACK, ST_DATA_ACK: sda_oe = 1'b1;
            ST_TX:                               sda_oe = ~shreg[BYTE_W-1];
            default:                             sda_oe = 1'b0;
        endcase
    end

    // R11: the data line moves only while the clock is low
    a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> (!$past(scl_s) || $past(start_evt) || $past(stop_evt)));

    // R9: a START always reopens selection-byte reception from bit zero
    a_r9_start_to_id: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == ST_ID) && (bit_cnt == '0));

    // R10: a STOP always returns the machine to idle
    a_r10_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (state == ST_IDLE));

    // R5: the commit pulse lasts one cycle
    a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

endmodule

// File: rtl/wiper_i2c_port.sv
module wiper_i2c_port #(
    parameter int DATA_W      = 7,
    parameter int SYNC_STAGES = 2,
    parameter int RESET_VALUE = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [1:0]        strap_a,
    output logic              sda_oe,
    output logic              wr_strobe,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] wiper_q
);

    logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    wiper_i2c_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .strap     (strap_a),
        .rd_value  (wiper_q),
        .sda_oe    (sda_oe),
        .wr_pulse  (wr_strobe),
        .wr_byte   (wr_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wiper_q <= DATA_W'(RESET_VALUE);
        end else if (wr_strobe) begin
            wiper_q <= wr_data;
        end
    end

    // R5: the register moves only because of a commit pulse
    a_r5_reg_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (wiper_q != $past(wiper_q)) |-> $past(wr_strobe));

    // R5: a commit pulse loads the committed value
    a_r5_strobe_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> (wiper_q == $past(wr_data)));

endmodule

// File: tb/test_wiper_i2c_port.sv
module test_wiper_i2c_port;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic       sda_oe;
    logic       wr_strobe;
    logic [6:0] wr_data;
    logic [6:0] wiper_q;
    wire        sda_bus = sda_m & ~sda_oe;

    int n_cmp = 0;
    int n_bad = 0;
    int strobes = 0;
    int oe_hi_moves = 0;
    bit done = 1'b0;
    logic prev_oe = 1'b0;

    always #5 clk = ~clk;

    wiper_i2c_port i_wiper_i2c_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_m),
        .sda_in    (sda_bus),
        .strap_a   (strap),
        .sda_oe    (sda_oe),
        .wr_strobe (wr_strobe),
        .wr_data   (wr_data),
        .wiper_q   (wiper_q)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_strobe) strobes++;
            if (sda_oe !== prev_oe && scl_m) oe_hi_moves++;
            prev_oe = sda_oe;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_bit(input bit b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wq(); scl_m = 1'b1;
        repeat (Q/2) @(negedge clk);
        ack = (sda_bus == 1'b0);
        repeat (Q/2) @(negedge clk);
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(output logic [7:0] b, output bit oe_ninth);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1;
            repeat (Q/2) @(negedge clk);
            b[i] = sda_bus;
            repeat (Q/2) @(negedge clk);
            scl_m = 1'b0;
        end
        wq(); scl_m = 1'b1;
        repeat (Q/2) @(negedge clk);
        oe_ninth = sda_oe;
        repeat (Q/2) @(negedge clk);
        scl_m = 1'b0; wq();
    endtask

    function automatic logic [7:0] id_byte(input logic [1:0] s, input bit rd);
        return {5'b01010, s, rd};
    endfunction

    task automatic do_write(input logic [7:0] d, input string req);
        bit a;
        bus_start();
        send_byte(id_byte(strap, 1'b0), a); chk(a, {req, " R3 id ack"}, a, 1);
        send_byte(8'h00, a);                chk(a, {req, " R5 addr ack"}, a, 1);
        send_byte(d, a);                    chk(a, {req, " R5 data ack"}, a, 1);
        bus_stop();
    endtask

    task automatic do_read(input logic [6:0] exp, input string req);
        bit a;
        bit oe9;
        logic [7:0] b;
        bus_start();
        send_byte(id_byte(strap, 1'b1), a); chk(a, {req, " R3 read id ack"}, a, 1);
        recv_byte(b, oe9);
        chk(b == {1'b0, exp}, {req, " R7 read byte"}, b, {1'b0, exp});
        chk(!oe9, {req, " R8 released in master ack"}, oe9, 0);
        bus_stop();
    endtask

    task automatic t_reset();
        chk(wiper_q == 7'd64, "R1 reset wiper", wiper_q, 64);
        chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
        chk(strobes == 0 && wr_strobe == 1'b0, "R1 reset strobe", strobes, 0);
    endtask

    task automatic t_no_start();
        bit a;
        scl_m = 1'b0; wq();
        send_byte(id_byte(strap, 1'b0), a); chk(!a, "R2 id without start", a, 0);
        send_byte(8'h00, a);                chk(!a, "R2 addr without start", a, 0);
        send_byte(8'h11, a);                chk(!a, "R2 data without start", a, 0);
        bus_stop();
        chk(wiper_q == 7'd64, "R2 wiper kept", wiper_q, 64);
        chk(strobes == 0, "R2 no strobe", strobes, 0);
    endtask

    task automatic t_write_read();
        bit a;
        do_write(8'hAA, "wr AA");
        chk(wiper_q == 7'h2A, "R5 msb dropped", wiper_q, 'h2A);
        chk(strobes == 1, "R5 one strobe", strobes, 1);
        do_read(7'h2A, "rd 2A");
        scl_m = 1'b0; wq();
        send_byte(id_byte(strap, 1'b0), a); chk(!a, "R8 idle after stop", a, 0);
        bus_stop();
    endtask

    task automatic t_bad_id();
        bit a;
        bus_start();
        send_byte(id_byte(2'b11, 1'b0), a); chk(!a, "R4 strap mismatch nack", a, 0);
        send_byte(8'h00, a);                chk(!a, "R4 later byte ignored", a, 0);
        send_byte(8'h05, a);                chk(!a, "R4 data ignored", a, 0);
        bus_stop();
        bus_start();
        send_byte(8'h44, a);                chk(!a, "R4 prefix mismatch nack", a, 0);
        bus_stop();
        chk(wiper_q == 7'h2A, "R4 wiper kept", wiper_q, 'h2A);
    endtask

    task automatic t_bad_addr();
        bit a;
        bus_start();
        send_byte(id_byte(strap, 1'b0), a); chk(a, "R6 id ack", a, 1);
        send_byte(8'h01, a);                chk(!a, "R6 addr nack", a, 0);
        send_byte(8'h33, a);                chk(!a, "R6 data nack", a, 0);
        bus_stop();
        chk(wiper_q == 7'h2A && strobes == 1, "R6 no write", wiper_q, 'h2A);
    endtask

    task automatic t_restart();
        bit a;
        bit oe9;
        logic [7:0] b;
        bus_start();
        send_byte(id_byte(strap, 1'b0), a); chk(a, "R9 id ack", a, 1);
        send_byte(8'h00, a);                chk(a, "R9 addr ack", a, 1);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start();
        send_byte(id_byte(strap, 1'b1), a); chk(a, "R9 new id ack", a, 1);
        recv_byte(b, oe9);
        chk(b == 8'h2A, "R9 read after restart", b, 'h2A);
        bus_stop();
        chk(strobes == 1, "R9 partial write dropped", strobes, 1);
    endtask

    task automatic t_stop_abort();
        bit a;
        bus_start();
        send_byte(id_byte(strap, 1'b0), a); chk(a, "R10 id ack", a, 1);
        send_byte(8'h00, a);                chk(a, "R10 addr ack", a, 1);
        bus_stop();
        scl_m = 1'b0; wq();
        send_byte(8'h11, a);                chk(!a, "R10 data after stop nack", a, 0);
        bus_stop();
        chk(wiper_q == 7'h2A && strobes == 1, "R10 no write", wiper_q, 'h2A);
    endtask

    task automatic t_patterns();
        bit a;
        strap = 2'b01;
        do_write(8'h7F, "wr 7F");
        chk(wiper_q == 7'h7F, "R5 write 7F", wiper_q, 'h7F);
        do_read(7'h7F, "rd 7F");
        do_write(8'h80, "wr 80");
        chk(wiper_q == 7'h00, "R5 write 00", wiper_q, 0);
        do_read(7'h00, "rd 00");
        bus_start();
        send_byte(id_byte(2'b10, 1'b0), a); chk(!a, "R3 old strap nack", a, 0);
        bus_stop();
        chk(strobes == 3, "R5 strobe count", strobes, 3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_no_start();
        t_write_read();
        t_bad_id();
        t_bad_addr();
        t_restart();
        t_stop_abort();
        t_patterns();
        chk(oe_hi_moves == 0, "R11 sda_oe steady while scl high", oe_hi_moves, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule